// File: doc/BRIEF.md
# I2C EEPROM target controller

This block is the serial-bus side of a 256-byte nonvolatile memory. The memory itself is modelled as a register array. The block watches a two-wire bus for START and STOP conditions and answers its own device address. It supports single-byte writes, page writes of up to sixteen bytes, reads from the current address, reads from a chosen address, and reads that run across many bytes.

Written bytes are first collected in a page staging buffer. They go into the array only when the STOP condition arrives. After that, a programming window lasts a set number of clock cycles. During that window the block refuses to acknowledge its address, so a host can poll until the write has finished.

A write-protect input blocks all writes. A supervisor reset input aborts any transfer that is under way, but it lets a programming window that has already started run to its end. The block samples the bus through synchronizers on the system clock. It only ever pulls the data line low, through an output-enable.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A START is the data line falling while the clock line is high, and a STOP is the data line rising while the clock line is high. Before the first START, clock pulses on the bus get no response and no acknowledge.
- R2: The device byte is acknowledged on the ninth clock only when its bits 7:4 equal DEV_ID (default 4'b1010). Bits 3:1 are ignored. Bit 0 selects the direction: 1 is read and 0 is write. A mismatch gets no acknowledge.
- R3: A byte write sends the device byte, then the word address, then one data byte, and all three are acknowledged. The array changes only at the STOP that follows. If a repeated START comes before any STOP, the received data is dropped.
- R4: During a write, each data byte advances only address bits 3:0, and bits 7:4 stay the same. A seventeenth or later byte wraps around within the same 16-byte page and overwrites the earlier bytes.
- R5: For PROG_CYCLES clock cycles after a committing STOP, the device byte gets no acknowledge. After that window it is acknowledged again.
- R6: The address pointer always holds the last accessed address plus one. A read with no word address returns the byte at the pointer.
- R7: A random read is a write of the word address, then a repeated START with the read device byte, and it returns the byte at that address.
- R8: A master acknowledge after a read byte makes the block send the next byte. In reads, all 8 pointer bits advance, so the address goes from 0xFF to 0x00 and crosses page boundaries.
- R9: After a read byte gets a master non-acknowledge, the block releases the data line and stays quiet until the next START or STOP.
- R10: With wp high, the device byte and the word address are acknowledged, the first data byte is not acknowledged, and the array stays unchanged.
- R11: While sys_reset is high, any transfer in progress is dropped and the data line is released. A START is also ignored while sys_reset is high, so the device byte gets no acknowledge.
- R12: A programming window that has already started keeps running to its end even if sys_reset is raised. Its data lands in the array, and the window still blocks acknowledges until it ends.
- R13: After rst_n, sda_oe is low, the pointer is 0x00, and each array byte at address a holds a XOR 0x5A.
- R14: sda_oe changes only while the synchronized clock line is low, except when sys_reset, START or STOP forces a release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low reset that initialises the controller and the array |
| scl | input | 1 | Bus clock line |
| sda | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When high, the data line is pulled low |
| wp | input | 1 | Write protect; when high, data bytes are refused |
| sys_reset | input | 1 | Supervisor reset that aborts the current transfer |

## Verification
The bench builds the block with PROG_CYCLES set to 400 and keeps the default two-stage synchronizer and DEV_ID. A programming window of 400 cycles is longer than one address poll but shorter than the test between writes. This lets a single run show both the refused poll during programming and the accepted poll after it. The same window can also be overlapped by a sys_reset pulse, which checks that programming survives the reset. With sixteen-byte pages and 256 bytes of storage, the bench can wrap a page and run a read across the top of the address space.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
  localparam int AW        = 8;
  localparam int PAGE_BITS = 4;
  localparam int DEPTH     = 1 << AW;
  localparam int PAGE      = 1 << PAGE_BITS;

  typedef logic [AW-1:0]        addr_t;
  typedef logic [7:0]           byte_t;
  typedef logic [PAGE_BITS-1:0] idx_t;
  typedef logic [AW-PAGE_BITS-1:0] page_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_WADR, S_WDAT, S_ACK, S_RDAT, S_RACK, S_WAIT
  } bus_st_e;

  typedef enum logic [1:0] {NX_WADR, NX_WDAT, NX_RDAT, NX_WAIT} next_e;

  // contents the array holds straight after reset
  function automatic byte_t fill_value(addr_t a);
    return byte_t'(a) ^ 8'h5A;
  endfunction

  // write pointer step: only the in-page bits advance
  function automatic addr_t page_next(addr_t a);
    addr_t m;
    m = addr_t'(PAGE - 1);
    return (a & ~m) | ((a + addr_t'(1)) & m);
  endfunction

  // read pointer step: full-width increment with wrap
  function automatic addr_t seq_next(addr_t a);
    return a + addr_t'(1);
  endfunction
endpackage

// File: rtl/eep_line_sync.sv
`timescale 1ns/1ps
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_q    = scl_sh[STAGES-1];
  assign sda_q    = sda_sh[STAGES-1];
  assign scl_rise = scl_q & ~scl_p;
  assign scl_fall = ~scl_q & scl_p;
  assign start_ev = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_ev  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/eep_store.sv
`timescale 1ns/1ps
module eep_store
  import eep_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  buf_clr,
  input  logic  buf_we,
  input  idx_t  buf_idx,
  input  byte_t buf_data,
  input  logic  commit,
  input  page_t page_sel,
  input  addr_t rd_addr,
  output byte_t rd_data
);
  byte_t mem  [DEPTH];
  byte_t pbuf [PAGE];
  logic [PAGE-1:0] pvalid;

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= fill_value(addr_t'(i));
      pvalid <= '0;
    end else begin
      if (buf_clr) pvalid <= '0;
      else if (buf_we) pvalid[buf_idx] <= 1'b1;
      if (commit) begin
        for (int j = 0; j < PAGE; j++) begin
          if (pvalid[j]) mem[{page_sel, idx_t'(j)}] <= pbuf[j];
        end
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_prog_timer.sv
`timescale 1ns/1ps
module eep_prog_timer #(
  parameter int CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= '0;
    else if (load)        left <= CW'(CYCLES);
    else if (left != '0)  left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/eeprom_i2c_target.sv
`timescale 1ns/1ps
module eeprom_i2c_target
  import eep_pkg::*;
#(
  parameter logic [3:0] DEV_ID      = 4'b1010,
  parameter int         PROG_CYCLES = 625000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic sda_oe,
  input  logic wp,
  input  logic sys_reset
);
  // named internal events
  logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, commit, buf_clr, buf_we, byte_done, take;
  byte_t rd_data, byte_in;

  bus_st_e    st;
  next_e      nx, nx_d;
  logic [3:0] cnt;
  logic [6:0] shreg;
  logic       ack_go, ack_hold, oe, pending;
  addr_t      ptr;
  byte_t      tx;

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(commit), .busy(busy)
  );

  eep_store u_store (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_idx(ptr[PAGE_BITS-1:0]), .buf_data(byte_in), .commit(commit),
    .page_sel(ptr[AW-1:PAGE_BITS]), .rd_addr(ptr), .rd_data(rd_data)
  );

  assign byte_in   = {shreg, sda_q};
  assign byte_done = (st == S_DEV || st == S_WADR || st == S_WDAT) && scl_rise && (cnt == 4'd7);
  assign buf_we    = byte_done && (st == S_WDAT) && !wp && !sys_reset && !start_ev && !stop_ev;
  assign buf_clr   = start_ev && !sys_reset;
  assign commit    = stop_ev && pending && !sys_reset;
  assign sda_oe    = oe;

  // acknowledge decision for a completed byte
  always_comb begin
    take = 1'b0;
    nx_d = NX_WAIT;
    case (st)
      S_DEV: begin
        take = (byte_in[7:4] == DEV_ID) && !busy;
        nx_d = !take ? NX_WAIT : (byte_in[0] ? NX_RDAT : NX_WADR);
      end
      S_WADR: begin take = 1'b1; nx_d = NX_WDAT; end
      S_WDAT: begin take = !wp;  nx_d = wp ? NX_WAIT : NX_WDAT; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nx <= NX_WAIT; cnt <= '0; shreg <= '0;
      ack_go <= 1'b0; ack_hold <= 1'b0; oe <= 1'b0; pending <= 1'b0;
      ptr <= '0; tx <= '0;
    end else if (sys_reset) begin
      st <= S_IDLE; oe <= 1'b0; pending <= 1'b0; ack_hold <= 1'b0;
    end else if (start_ev) begin
      st <= S_DEV; cnt <= '0; oe <= 1'b0; pending <= 1'b0; ack_hold <= 1'b0;
    end else if (stop_ev) begin
      st <= S_IDLE; oe <= 1'b0; pending <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_WADR, S_WDAT: if (scl_rise) begin
          shreg <= byte_in[6:0];
          cnt   <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            st <= S_ACK; ack_hold <= 1'b0; ack_go <= take; nx <= nx_d;
            if (st == S_WADR) ptr <= byte_in;
            if (buf_we) begin
              ptr <= page_next(ptr);
              pending <= 1'b1;
            end
          end
        end
        S_ACK: if (scl_fall) begin
          if (!ack_hold) begin
            oe <= ack_go; ack_hold <= 1'b1;
          end else begin
            ack_hold <= 1'b0; cnt <= '0;
            case (nx)
              NX_WADR: begin st <= S_WADR; oe <= 1'b0; end
              NX_WDAT: begin st <= S_WDAT; oe <= 1'b0; end
              NX_RDAT: begin
                st <= S_RDAT; tx <= rd_data; oe <= ~rd_data[7]; ptr <= seq_next(ptr);
              end
              default: begin st <= S_WAIT; oe <= 1'b0; end
            endcase
          end
        end
        S_RDAT: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe <= 1'b0; st <= S_RACK; ack_hold <= 1'b0;
            end else oe <= ~tx[~cnt[2:0]];
          end
        end
        S_RACK: begin
          if (scl_rise && !ack_hold) begin
            ack_hold <= 1'b1; ack_go <= ~sda_q;
          end else if (scl_fall && ack_hold) begin
            ack_hold <= 1'b0; cnt <= '0;
            if (ack_go) begin
              st <= S_RDAT; tx <= rd_data; oe <= ~rd_data[7]; ptr <= seq_next(ptr);
            end else begin
              st <= S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_i2c_target_chk.sv
`timescale 1ns/1ps
module eeprom_i2c_target_chk
  import eep_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    sys_reset,
  input logic    scl_q,
  input logic    start_ev,
  input logic    stop_ev,
  input logic    sda_oe,
  input logic    busy,
  input logic    commit,
  input bus_st_e st
);
  // R14
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(sys_reset) && !$past(start_ev || stop_ev)) |-> !scl_q);

  // R11
  sysrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset |=> !sda_oe);

  // R5
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  // R3
  commit_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (st == S_WDAT));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .scl_q(scl_q),
  .start_ev(start_ev), .stop_ev(stop_ev), .sda_oe(sda_oe),
  .busy(busy), .commit(commit), .st(st)
);

// File: tb/eeprom_i2c_target_test.sv
`timescale 1ns/1ps
module eeprom_i2c_target_test;
  localparam int PROG = 400;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0, sys_reset = 1'b0;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;
  logic [7:0] mdl [256];
  logic [7:0] rbuf [32];

  always #4 clk = ~clk;

  eeprom_i2c_target #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .scl(scl_m), .sda(sda_bus),
    .sda_oe(sda_oe), .wp(wp), .sys_reset(sys_reset)
  );

  // {op(1=write,0=read), address, data}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 8'h12, 8'hC3}, {1'b0, 8'h12, 8'h00},
    {1'b1, 8'h13, 8'h00}, {1'b0, 8'h13, 8'h00},
    {1'b0, 8'h80, 8'h00}, {1'b1, 8'hFF, 8'h7E},
    {1'b0, 8'hFF, 8'h00}, {1'b0, 8'h00, 8'h00}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF); scl_m = 1'b0; tick(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HALF); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HALF); scl_m = 1'b1; tick(HALF); scl_m = 1'b0; tick(1);
    end
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF);
    ackd = !sda_bus;
    scl_m = 1'b0; tick(1);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(HALF); scl_m = 1'b1; tick(HALF); d = {d[6:0], sda_bus}; scl_m = 1'b0; tick(1);
    end
    sda_m = !mack; tick(HALF); scl_m = 1'b1; tick(HALF); scl_m = 1'b0; tick(1);
    sda_m = 1'b1;
  endtask

  // random read of n bytes from a into rbuf
  task automatic rand_read(input logic [7:0] a, input int n);
    logic k;
    bus_start(); put_byte(8'hA0, k); put_byte(a, k);
    bus_start(); put_byte(8'hA1, k);
    for (int i = 0; i < n; i++) get_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic byte_write(input logic [7:0] a, input logic [7:0] d, input string req);
    logic k;
    bus_start();
    put_byte(8'hA0, k); check(req, k, 1);
    put_byte(a, k);     check(req, k, 1);
    put_byte(d, k);     check(req, k, 1);
    bus_stop();
  endtask

  initial begin
    logic k;
    logic [7:0] d;
    for (int a = 0; a < 256; a++) mdl[a] = 8'(a) ^ 8'b0101_1010;
    tick(5); rst_n = 1'b1; tick(5);

    // R13: reset state
    check("R13 sda_oe after reset", sda_oe, 0);
    bus_start(); put_byte(8'hA1, k); get_byte(1'b0, d); bus_stop();
    check("R13/R6 pointer zero after reset", d, mdl[0]);

    // vector table walk
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][16]) begin
        byte_write(VEC[v][15:8], VEC[v][7:0], "R3 table write ack");
        mdl[VEC[v][15:8]] = VEC[v][7:0];
        tick(PROG + 40);
      end else begin
        rand_read(VEC[v][15:8], 1);
        check("R7 table random read", rbuf[0], mdl[VEC[v][15:8]]);
      end
    end

    // R2: address match
    bus_start(); put_byte(8'hB0, k); bus_stop();
    check("R2 foreign id nack", k, 0);
    bus_start(); put_byte(8'hAE, k); bus_stop();
    check("R2 select bits ignored", k, 1);

    // R1: no START, no response
    put_byte(8'hA0, k);
    check("R1 no ack without start", k, 0);
    bus_stop();

    // R4: 18-byte page write from 0x3E wraps in page 0x30
    bus_start(); put_byte(8'hA0, k); put_byte(8'h3E, k);
    for (int i = 0; i < 18; i++) begin
      put_byte(8'(8'h80 + i), k);
      mdl[{4'h3, 4'(14 + i)}] = 8'(8'h80 + i);
    end
    bus_stop(); tick(PROG + 40);
    rand_read(8'h30, 17);
    for (int i = 0; i < 16; i++) check("R4 page wrap content", rbuf[i], mdl[8'h30 + i]);
    check("R8 read crosses page", rbuf[16], mdl[8'h40]);

    // R5: busy polling
    byte_write(8'h55, 8'h99, "R3 write for poll");
    mdl[8'h55] = 8'h99;
    bus_start(); put_byte(8'hA0, k); bus_stop();
    check("R5 nack while programming", k, 0);
    tick(PROG + 20);
    bus_start(); put_byte(8'hA0, k); bus_stop();
    check("R5 ack after programming", k, 1);
    rand_read(8'h55, 1);
    check("R3 committed at stop", rbuf[0], 8'h99);

    // R3: repeated START discards data
    bus_start(); put_byte(8'hA0, k); put_byte(8'h60, k); put_byte(8'h11, k);
    bus_start(); put_byte(8'hA1, k); get_byte(1'b0, d); bus_stop();
    check("R6 pointer after write byte", d, mdl[8'h61]);
    rand_read(8'h60, 1);
    check("R3 no commit without stop", rbuf[0], mdl[8'h60]);

    // R6: current address follows last read
    rand_read(8'h90, 1);
    bus_start(); put_byte(8'hA1, k); get_byte(1'b0, d); bus_stop();
    check("R6 current address read", d, mdl[8'h91]);

    // R8: wrap 0xFF -> 0x00
    rand_read(8'hFE, 3);
    check("R8 seq byte0", rbuf[0], mdl[8'hFE]);
    check("R8 seq byte1", rbuf[1], mdl[8'hFF]);
    check("R8 seq wrap", rbuf[2], mdl[8'h00]);

    // R9: master nack releases the line
    bus_start(); put_byte(8'hA0, k); put_byte(8'h20, k);
    bus_start(); put_byte(8'hA1, k); get_byte(1'b0, d);
    tick(4);
    check("R9 released after nack", sda_oe, 0);
    tick(HALF); scl_m = 1'b1; tick(HALF);
    check("R9 line high on extra clock", sda_bus, 1);
    scl_m = 1'b0; tick(1);
    bus_stop();

    // R10: write protect
    wp = 1'b1;
    bus_start();
    put_byte(8'hA0, k); check("R10 wp device ack", k, 1);
    put_byte(8'h70, k); check("R10 wp word ack", k, 1);
    put_byte(8'hEE, k); check("R10 wp data nack", k, 0);
    bus_stop();
    wp = 1'b0; tick(PROG + 20);
    rand_read(8'h70, 1);
    check("R10 wp left array", rbuf[0], mdl[8'h70]);

    // R11: supervisor reset aborts and blocks
    bus_start(); put_byte(8'hA0, k); put_byte(8'h71, k);
    sys_reset = 1'b1; tick(3);
    check("R11 line released", sda_oe, 0);
    put_byte(8'h44, k);
    check("R11 data ignored", k, 0);
    bus_stop();
    bus_start(); put_byte(8'hA0, k); bus_stop();
    check("R11 start ignored", k, 0);
    sys_reset = 1'b0; tick(PROG + 20);
    rand_read(8'h71, 1);
    check("R11 aborted write dropped", rbuf[0], mdl[8'h71]);

    // R12: programming survives supervisor reset
    byte_write(8'h72, 8'h3C, "R12 write ack");
    mdl[8'h72] = 8'h3C;
    sys_reset = 1'b1; tick(50); sys_reset = 1'b0; tick(2);
    bus_start(); put_byte(8'hA0, k); bus_stop();
    check("R12 still busy after reset", k, 0);
    tick(PROG + 20);
    rand_read(8'h72, 1);
    check("R12 data landed", rbuf[0], 8'h3C);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule